// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 32 interrupt sources and raises one request line toward a processor. Each source can be set to react to a level or to an edge. Each one carries its own 3-bit priority and its own 32-bit vector word, and can be enabled or disabled one bit at a time. When the processor reads the vector register, the controller returns the vector of the best source that is pending and enabled. That read also acknowledges the source: the current handling level goes onto an eight-entry stack and the level rises to the priority of that source.

From then on, only a source of strictly higher priority can raise the request line again, so interrupts nest. Each end-of-interrupt write pops one level off the stack. If no source qualifies, a vector read returns a programmable spurious word and changes nothing. A protect bit makes vector reads free of side effects, for debuggers. While it is set, the acknowledge happens on a write to the vector register instead.

The register interface uses single-cycle strobes. The word address is 7 bits: 0..31 are the per-source mode words and 32..63 are the per-source vector words. The command and status words sit at 64 (vector/acknowledge), 65 (spurious word), 66 (enable-set), 67 (enable-clear), 68 (enable mask), 69 (pending-clear), 70 (end of interrupt) and 71 (protect, bit 0). Read data is registered and valid on the cycle after the read strobe. Reads of unmapped addresses, or of the write-only command words, return 0.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: After reset the request line is low, the enable mask reads 0, the spurious word reads 0, all mode and vector words read 0, the level is idle and the stack is empty.
- R2: A write to enable-set (66) sets each mask bit whose data bit is 1, and a write to enable-clear (67) clears each one. Data bits of 0 leave the mask alone. Address 68 reads the mask back. A disabled source never raises the request line.
- R3: A mode word holds the priority in bits [2:0] and the trigger type in bits [5:4]: 00 high level, 01 rising edge, 10 low level, 11 falling edge. Bit 3 reads 0. Source 0 and the sources marked external (default 29..31) keep all four types. On every other source, type bit 5 is stored as 0, so a write of 10 or 11 becomes 00 or 01.
- R4: A level source is pending only while its synchronised input is at the active level, and nothing is latched. A change on the input reaches the request line two clocks later.
- R5: An edge source latches a pending flag on its active edge. The edge is seen on the third clock after the input changes. The flag stays set until a pending-clear (69) write with that bit set, or until that source is acknowledged. A new edge in the same cycle wins over a clear.
- R6: The selected source is the pending, enabled source with the highest priority, where 7 is highest. On a tie the lowest source number wins. A vector read returns that source's vector word when the selected priority is above the current level.
- R7: A vector read with no source above the current level returns the spurious word (65) and leaves the level and the stack unchanged.
- R8: A vector read with protect clear acknowledges the selected source. It pushes the current level, sets the level to that source's priority and clears that source's edge flag. After that, the request line is high only while some pending, enabled source has strictly higher priority.
- R9: Each write to end-of-interrupt (70), whatever the data, restores the level from the top of the eight-entry stack. On an empty stack the write has no effect.
- R10: With the protect bit set, a vector read returns the same vector with no acknowledge. A write to the vector register then performs the acknowledge.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Raw interrupt source inputs |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 7 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data, valid the cycle after rdEn |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench drives two sources of equal priority at once. A controller that broke ties toward the higher source number would return the wrong vector. It nests a priority-5 acknowledge on top of a priority-4 one, then unwinds through an end-of-interrupt on an empty stack. A wrong pop order, or an underflow, would leave the request line stuck low or let an equal priority through. It checks that an edge flag stays latched after the input has dropped and that the acknowledge clears it. A controller that treated edges as levels, or never cleared the flag, would lose the interrupt or fire it twice. It also shows that reads under protect leave the level untouched, that a low-level type written to an internal source becomes high level, and that a disabled source still asserting stays silent.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC   = 32;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int PRIO_W = 3;
  localparam int LVL_W  = PRIO_W + 1;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] A_IVR   = 7'd64;
  localparam logic [ADDR_W-1:0] A_SPU   = 7'd65;
  localparam logic [ADDR_W-1:0] A_ENSET = 7'd66;
  localparam logic [ADDR_W-1:0] A_ENCLR = 7'd67;
  localparam logic [ADDR_W-1:0] A_MASK  = 7'd68;
  localparam logic [ADDR_W-1:0] A_PCLR  = 7'd69;
  localparam logic [ADDR_W-1:0] A_EOI   = 7'd70;
  localparam logic [ADDR_W-1:0] A_PROT  = 7'd71;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_FALL = 2'b11
  } trig_t;

  typedef struct packed {
    logic              modeWr;
    logic              vecWr;
    logic              enSet;
    logic              enClr;
    logic              pendClr;
    logic              ack;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } dpCmd_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter logic [NSRC-1:0] EXT_MASK = 32'hE000_0000,
  parameter int              FAST_SRC = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   irqIn,
  input  dpCmd_t            cmd,
  output logic              bestValid,
  output logic [PRIO_W-1:0] bestPrio,
  output logic [DATA_W-1:0] bestVec,
  output logic [DATA_W-1:0] modeRd,
  output logic [DATA_W-1:0] vecRd,
  output logic [NSRC-1:0]   maskQ
);
  logic [NSRC-1:0] syncA, syncB, syncPrev;
  logic [NSRC-1:0] pendAll;
  logic [NSRC-1:0][PRIO_W-1:0] prioAll;
  logic [NSRC-1:0][1:0]        trigAll;
  logic [NSRC-1:0][DATA_W-1:0] vecAll;
  logic [IDX_W-1:0] bestIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncPrev <= '0;
      maskQ <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      syncPrev <= syncB;
      if (cmd.enSet) maskQ <= maskQ | cmd.data[NSRC-1:0];
      else if (cmd.enClr) maskQ <= maskQ & ~cmd.data[NSRC-1:0];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam bit CAN_INVERT = EXT_MASK[i] || (i == FAST_SRC);
    logic [PRIO_W-1:0] prio;
    logic [1:0]        trig;
    logic [DATA_W-1:0] vec;
    logic              edgeFlag;
    logic              activeNow, activeOld, edgeHit, clrHit, sel;
    logic              invBit;

    assign sel = (cmd.idx == IDX_W'(i));
    if (CAN_INVERT) begin : g_full
      assign invBit = cmd.data[5];
    end else begin : g_plain
      assign invBit = 1'b0;
    end

    assign activeNow = trig[1] ? ~syncB[i] : syncB[i];
    assign activeOld = trig[1] ? ~syncPrev[i] : syncPrev[i];
    assign edgeHit   = trig[0] & activeNow & ~activeOld;
    assign clrHit    = (cmd.pendClr & cmd.data[i]) |
                       (cmd.ack & (bestIdx == IDX_W'(i)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prio <= '0;
        trig <= TRIG_HIGH;
        vec <= '0;
        edgeFlag <= 1'b0;
      end else begin
        if (cmd.modeWr && sel) begin
          prio <= cmd.data[PRIO_W-1:0];
          trig <= {invBit, cmd.data[4]};
        end
        if (cmd.vecWr && sel) vec <= cmd.data;
        edgeFlag <= (edgeFlag & ~clrHit) | edgeHit;
      end
    end

    assign pendAll[i] = trig[0] ? edgeFlag : activeNow;
    assign prioAll[i] = prio;
    assign trigAll[i] = trig;
    assign vecAll[i]  = vec;
  end

  always_comb begin
    bestValid = 1'b0;
    bestPrio  = '0;
    bestIdx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pendAll[i] && maskQ[i] && (!bestValid || prioAll[i] >= bestPrio)) begin
        bestValid = 1'b1;
        bestPrio  = prioAll[i];
        bestIdx   = IDX_W'(i);
      end
    end
  end

  assign bestVec = vecAll[bestIdx];
  assign modeRd  = DATA_W'({trigAll[cmd.idx], 1'b0, prioAll[cmd.idx]});
  assign vecRd   = vecAll[cmd.idx];
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int SP_W  = $clog2(STACK_DEPTH + 1),
  localparam int STK_W = $clog2(STACK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bestValid,
  input  logic [PRIO_W-1:0] bestPrio,
  input  logic [DATA_W-1:0] bestVec,
  input  logic [DATA_W-1:0] modeRd,
  input  logic [DATA_W-1:0] vecRd,
  input  logic [NSRC-1:0]   maskQ,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [SP_W-1:0]   stackPtr,
  output logic              protQ
);
  logic [LVL_W-1:0] curLvl;
  logic [LVL_W-1:0] stackMem [STACK_DEPTH];
  logic [DATA_W-1:0] spuQ;
  logic [SP_W-1:0] spDec;
  logic eligible, ackNow, popNow, inModes, inVecs;
  logic [LVL_W-1:0] selLvl;

  assign selLvl   = {1'b0, bestPrio} + LVL_W'(1);
  assign eligible = bestValid && (selLvl > curLvl);
  assign ackNow   = eligible && (addr == A_IVR) &&
                    ((rdEn && !protQ) || (wrEn && protQ));
  assign popNow   = wrEn && (addr == A_EOI) && (stackPtr != '0);
  assign spDec    = stackPtr - SP_W'(1);
  assign inModes  = (addr[ADDR_W-1:ADDR_W-2] == 2'b00);
  assign inVecs   = (addr[ADDR_W-1:ADDR_W-2] == 2'b01);
  assign irqOut   = eligible;

  always_comb begin
    cmd.modeWr  = wrEn && inModes;
    cmd.vecWr   = wrEn && inVecs;
    cmd.enSet   = wrEn && (addr == A_ENSET);
    cmd.enClr   = wrEn && (addr == A_ENCLR);
    cmd.pendClr = wrEn && (addr == A_PCLR);
    cmd.ack     = ackNow;
    cmd.idx     = addr[IDX_W-1:0];
    cmd.data    = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLvl <= '0;
      stackPtr <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) stackMem[i] <= '0;
    end else if (ackNow && (stackPtr < SP_W'(STACK_DEPTH))) begin
      stackMem[stackPtr[STK_W-1:0]] <= curLvl;
      stackPtr <= stackPtr + SP_W'(1);
      curLvl <= selLvl;
    end else if (popNow) begin
      curLvl <= stackMem[spDec[STK_W-1:0]];
      stackPtr <= spDec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spuQ <= '0;
      protQ <= 1'b0;
      rdData <= '0;
    end else begin
      if (wrEn && addr == A_SPU) spuQ <= wrData;
      if (wrEn && addr == A_PROT) protQ <= wrData[0];
      if (rdEn) begin
        if (inModes) rdData <= modeRd;
        else if (inVecs) rdData <= vecRd;
        else begin
          case (addr)
            A_IVR:   rdData <= eligible ? bestVec : spuQ;
            A_SPU:   rdData <= spuQ;
            A_MASK:  rdData <= DATA_W'(maskQ);
            A_PROT:  rdData <= DATA_W'(protQ);
            default: rdData <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/vectored_irq_ctrl.sv
module vectored_irq_ctrl
  import vic_pkg::*;
#(
  parameter logic [NSRC-1:0] EXT_MASK    = 32'hE000_0000,
  parameter int              FAST_SRC    = 0,
  parameter int              STACK_DEPTH = 8,
  localparam int             SP_W        = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   irqIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  dpCmd_t cmd;
  logic bestValid;
  logic [PRIO_W-1:0] bestPrio;
  logic [DATA_W-1:0] bestVec, modeRd, vecRd;
  logic [NSRC-1:0] maskQ;
  logic [SP_W-1:0] stackPtr;
  logic protQ;

  vic_datapath #(.EXT_MASK(EXT_MASK), .FAST_SRC(FAST_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cmd(cmd),
    .bestValid(bestValid), .bestPrio(bestPrio), .bestVec(bestVec),
    .modeRd(modeRd), .vecRd(vecRd), .maskQ(maskQ)
  );

  vic_control #(.STACK_DEPTH(STACK_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .bestValid(bestValid), .bestPrio(bestPrio),
    .bestVec(bestVec), .modeRd(modeRd), .vecRd(vecRd), .maskQ(maskQ),
    .cmd(cmd), .rdData(rdData), .irqOut(irqOut), .stackPtr(stackPtr),
    .protQ(protQ)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              irqOut,
  input logic [NSRC-1:0]   maskQ,
  input logic [SP_W-1:0]   stackPtr,
  input logic              protQ
);
  // R9: the stack never grows past its depth
  a_r9_stack_bound: assert property (@(posedge clk) disable iff (!rstN)
    stackPtr <= SP_W'(STACK_DEPTH));

  // R8: an unprotected vector read while requesting pushes one level
  a_r8_ack_push: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == A_IVR && !protQ && irqOut)
    |=> (stackPtr == $past(stackPtr) + 1'b1));

  // R10: a protected vector read leaves the stack alone
  a_r10_prot_read_still: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == A_IVR && protQ) |=> $stable(stackPtr));

  // R9: an end-of-interrupt write pops one level
  a_r9_eoi_pop: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && addr == A_EOI && stackPtr != '0)
    |=> (stackPtr == $past(stackPtr) - 1'b1));

  // R9: an end-of-interrupt write on an empty stack has no effect
  a_r9_eoi_empty: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && addr == A_EOI && stackPtr == '0) |=> (stackPtr == '0));

  // R2: no request without some enabled source
  a_r2_irq_enabled: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ != '0));
endmodule

bind vectored_irq_ctrl vic_checker #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .irqOut(irqOut), .maskQ(maskQ), .stackPtr(stackPtr), .protQ(protQ)
);

// File: tb/vectored_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vectored_irq_ctrl_tb;
  logic clk = 0;
  logic rstN = 0;
  logic [31:0] irqIn = '0;
  logic wrEn = 0, rdEn = 0;
  logic [6:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vectored_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // ---------------- reference model ----------------
  localparam bit [31:0] EXT = 32'hE000_0000;
  int mPrio [32];
  int mTrig [32];
  bit [31:0] mVec [32];
  bit [31:0] mMask, mSpu, mRd, mPend, mS1, mS2, mS2d;
  bit mProt;
  int mLvl;
  int mStk [$];

  function automatic bit srcPend(int i);
    bit lv;
    lv = (mTrig[i] >= 2) ? !mS2[i] : mS2[i];
    return (mTrig[i] % 2 == 1) ? mPend[i] : lv;
  endfunction

  function automatic void pick(output bit v, output int si, output int pr);
    v = 0; si = 0; pr = 0;
    for (int i = 0; i < 32; i++)
      if (mMask[i] && srcPend(i) && (!v || mPrio[i] > pr)) begin
        v = 1; si = i; pr = mPrio[i];
      end
  endfunction

  function automatic bit expIrq();
    bit v; int si, pr;
    pick(v, si, pr);
    return v && (pr + 1 > mLvl);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) begin mPrio[i] = 0; mTrig[i] = 0; mVec[i] = 0; end
      mMask = 0; mSpu = 0; mRd = 0; mPend = 0; mS1 = 0; mS2 = 0; mS2d = 0;
      mProt = 0; mLvl = 0; mStk.delete();
    end else begin
      bit v, el, ackNow;
      int si, pr;
      bit [31:0] np;
      pick(v, si, pr);
      el = v && (pr + 1 > mLvl);
      if (rdEn) begin
        if (addr < 32) mRd = (mTrig[addr] << 4) | mPrio[addr];
        else if (addr < 64) mRd = mVec[addr - 32];
        else if (addr == 64) mRd = el ? mVec[si] : mSpu;
        else if (addr == 65) mRd = mSpu;
        else if (addr == 68) mRd = mMask;
        else if (addr == 71) mRd = {31'b0, mProt};
        else mRd = 0;
      end
      ackNow = el && (addr == 64) && ((rdEn && !mProt) || (wrEn && mProt));
      for (int i = 0; i < 32; i++) begin
        bit act, prv, hit, clr;
        act = (mTrig[i] >= 2) ? !mS2[i] : mS2[i];
        prv = (mTrig[i] >= 2) ? !mS2d[i] : mS2d[i];
        hit = (mTrig[i] % 2 == 1) && act && !prv;
        clr = (wrEn && addr == 69 && wrData[i]) || (ackNow && si == i);
        np[i] = (mPend[i] && !clr) || hit;
      end
      if (ackNow && mStk.size() < 8) begin
        mStk.push_back(mLvl);
        mLvl = pr + 1;
      end else if (wrEn && addr == 70 && mStk.size() > 0) begin
        mLvl = mStk.pop_back();
      end
      if (wrEn) begin
        if (addr < 32) begin
          int t;
          mPrio[addr] = wrData[2:0];
          t = wrData[5:4];
          if (!(EXT[addr] || addr == 0)) t = t & 1;
          mTrig[addr] = t;
        end else if (addr < 64) mVec[addr - 32] = wrData;
        else if (addr == 65) mSpu = wrData;
        else if (addr == 66) mMask = mMask | wrData;
        else if (addr == 67) mMask = mMask & ~wrData;
        else if (addr == 71) mProt = wrData[0];
      end
      mPend = np;
      mS2d = mS2; mS2 = mS1; mS1 = irqIn;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit e;
      e = expIrq();
      nChecks++;
      if (irqOut !== e) begin
        nFails++;
        $display("FAIL R6 model irqOut act=%0d exp=%0d t=%0t", irqOut, e, $time);
      end
      nChecks++;
      if (rdData !== mRd) begin
        nFails++;
        $display("FAIL R6 model rdData act=%h exp=%h t=%0t", rdData, mRd, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0; wrData = '0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] v);
    @(negedge clk); rdEn = 1; addr = a;
    @(negedge clk); rdEn = 0;
    v = rdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #500000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    irqIn[0] = 1'b1;
    idle(3);
    rstN = 1;
    idle(1);
    chk("R1 irqOut after reset", {31'b0, irqOut}, 0);
    rd(68, v); chk("R1 mask after reset", v, 0);
    rd(3, v); chk("R1 mode word after reset", v, 0);
    rd(64, v); chk("R7 spurious reset value", v, 0);

    wr(65, 32'h55);
    for (int i = 0; i < 32; i++) wr(7'(32 + i), 32'h100 + i);
    rd(64, v); chk("R7 spurious vector", v, 32'h55);
    rd(41, v); chk("R1 vector word readback", v, 32'h109);

    wr(66, 32'h28); wr(67, 32'h08);
    rd(68, v); chk("R2 set then clear", v, 32'h20);
    wr(66, 32'h200);
    rd(68, v); chk("R2 zero bits unchanged", v, 32'h220);

    wr(3, 32'h25); rd(3, v); chk("R3 internal low forced high", v, 32'h05);
    wr(30, 32'h32); rd(30, v); chk("R3 external falling kept", v, 32'h32);
    wr(0, 32'h27); rd(0, v); chk("R3 fast source low kept", v, 32'h27);

    // level source
    wr(5, 32'h02);
    irqIn[5] = 1; idle(4);
    chk("R4 level raises irq", {31'b0, irqOut}, 1);
    rd(64, v); chk("R6 vector of level source", v, 32'h105);
    chk("R8 irq low after ack", {31'b0, irqOut}, 0);
    irqIn[5] = 0; wr(70, 0); idle(4);
    chk("R4 level not latched", {31'b0, irqOut}, 0);
    rd(64, v); chk("R7 nothing eligible", v, 32'h55);

    // edge source
    wr(9, 32'h14);
    irqIn[9] = 1; idle(2); irqIn[9] = 0; idle(4);
    chk("R5 edge latched", {31'b0, irqOut}, 1);
    wr(69, 32'h200); idle(1);
    chk("R5 pending clear", {31'b0, irqOut}, 0);

    // priority and nesting
    wr(3, 32'h05); wr(66, 32'h08);
    irqIn[3] = 1; irqIn[5] = 1;
    irqIn[9] = 1; idle(2); irqIn[9] = 0; idle(3);
    rd(64, v); chk("R6 highest priority wins", v, 32'h103);
    chk("R8 lower sources blocked", {31'b0, irqOut}, 0);
    irqIn[3] = 0; idle(3); wr(70, 0); idle(1);
    chk("R9 eoi restores idle", {31'b0, irqOut}, 1);
    rd(64, v); chk("R8 edge source acked", v, 32'h109);
    chk("R8 equal-or-lower blocked", {31'b0, irqOut}, 0);
    irqIn[3] = 1; idle(4);
    chk("R8 strictly higher nests", {31'b0, irqOut}, 1);
    rd(64, v); chk("R8 nested vector", v, 32'h103);
    irqIn[3] = 0; idle(3);
    wr(70, 0);
    chk("R9 pop back to level 4", {31'b0, irqOut}, 0);
    wr(70, 0);
    chk("R9 pop to idle", {31'b0, irqOut}, 1);
    wr(70, 0);
    chk("R9 empty eoi harmless", {31'b0, irqOut}, 1);
    rd(64, v); chk("R9 after empty eoi", v, 32'h105);
    wr(70, 0);

    // protect mode
    wr(71, 1);
    rd(64, v); chk("R10 protected read vector", v, 32'h105);
    chk("R10 no ack on read", {31'b0, irqOut}, 1);
    rd(64, v); chk("R10 repeat read", v, 32'h105);
    wr(64, 0);
    chk("R10 write acks", {31'b0, irqOut}, 0);
    wr(70, 0); wr(71, 0);
    rd(71, v); chk("R10 protect readback", v, 0);

    // tie and falling edge on external source
    wr(66, 32'h4000_0000);
    irqIn[30] = 1; idle(4); irqIn[30] = 0; idle(4);
    rd(64, v); chk("R6 tie lower index", v, 32'h105);
    wr(70, 0);
    irqIn[5] = 0; idle(4);
    rd(64, v); chk("R3 falling edge vector", v, 32'h11E);
    wr(70, 0); idle(1);
    chk("R8 ack cleared edge", {31'b0, irqOut}, 0);

    // disabled source
    irqIn[5] = 1; wr(67, 32'h20); idle(4);
    chk("R2 disabled source silent", {31'b0, irqOut}, 0);

    // low level on the fast source
    irqIn[0] = 0; idle(3);
    wr(66, 32'h1); idle(1);
    chk("R3 low level active", {31'b0, irqOut}, 1);
    rd(64, v); chk("R6 fast source vector", v, 32'h100);
    wr(70, 0);
    idle(3);
    finishRun();
  end
endmodule